// File: doc/BRIEF.md
# Accumulator Processor Arithmetic Logic Unit

This block is the purely combinational arithmetic and logic stage of a small accumulator processor. One operand is the current accumulator value, the other is a data word fetched from memory or taken from an immediate field. A four-bit operation code selects one of twelve functions. These are copying either operand, stepping the accumulator up or down by one, inverting it, combining the two operands with OR or XOR, adding them with or without an incoming carry, subtracting with an incoming borrow, and moving the accumulator one place left or right.

Next to the data result the block reports four status bits: carry/borrow, sign, zero and two's-complement overflow. The surrounding datapath registers the result into the accumulator and captures the status bits. Neither of those registers lives here, so every output follows its inputs within the same cycle. The data width is a parameter, 16 bits by default. The operation codes are fixed.

Top module: `acc_alu`

## Requirements
- R1: Code 0000 gives `op_a`, code 0001 gives `op_b`, and the unused codes 1100, 1101, 1110 and 1111 give `op_a`. In all of these, carry and overflow are 0.
- R2: Code 0010 gives `op_a`+1, with carry set when the sum wraps past all ones. Code 0011 gives `op_a`-1, with carry set as a borrow when `op_a` is zero.
- R3: Code 0100 gives the bitwise inverse of `op_a`, code 0110 gives `op_a` OR `op_b`, and code 0111 gives `op_a` XOR `op_b`. In all three, carry and overflow are 0.
- R4: Code 0101 gives `op_a`+`op_b` and ignores `carry_in`. Code 1000 gives `op_a`+`op_b`+`carry_in`. In both, carry is the carry out of the top bit.
- R5: Code 1001 gives `op_a`-`op_b`-`carry_in`, where `carry_in` acts as an incoming borrow. Carry is 1 exactly when `op_a` is less than `op_b`+`carry_in`, both taken as unsigned.
- R6: Overflow is signed two's-complement overflow for codes 0010, 0011, 0101, 1000 and 1001, and is 0 for every other code.
- R7: Code 1010 moves `op_a` right by one and fills the top bit with 0. Carry is the old bit 0. Code 1011 moves `op_a` left by one and fills bit 0 with 0. Carry is the old top bit.
- R8: For every code, the zero flag is 1 exactly when the result is all zeros, and the sign flag equals the top bit of the result.
- R9: `carry_in` has no effect on any output for codes other than 1000 and 1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W (16) | Accumulator operand |
| op_b | input | W (16) | Memory or immediate operand |
| carry_in | input | 1 | Incoming carry (code 1000) or borrow (code 1001) |
| mode | input | 4 | Operation code |
| result | output | W (16) | Operation result |
| flag_carry | output | 1 | Carry out, borrow, or the bit moved out |
| flag_sign | output | 1 | Top bit of the result |
| flag_zero | output | 1 | Result is all zeros |
| flag_ovf | output | 1 | Signed overflow of the arithmetic codes |

## Verification
Carry generation and zero detection can both fire on the same operation. So can overflow and zero. The bench provokes this by wrapping `0xFFFF` by an increment or by adding one, by adding `0x8000` to itself, by subtracting `0xFFFF` with an incoming borrow from zero, and by moving a lone low bit out to the right. Each of these vectors expects carry and zero set together, and where signed wrap occurs overflow as well. The full result and the four flags are compared as one word, so a flag that blocks or masks another is reported.

// File: rtl/acc_alu_pkg.sv
// Package acc_alu_pkg
// Shared operation codes and helpers for the accumulator ALU.
// Assumes a 4-bit operation code; the code values are fixed by the
// instruction decoder and must not be renumbered.
package acc_alu_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        OP_PASS_A = 4'h0,
        OP_PASS_B = 4'h1,
        OP_INC    = 4'h2,
        OP_DEC    = 4'h3,
        OP_NOT    = 4'h4,
        OP_ADD    = 4'h5,
        OP_OR     = 4'h6,
        OP_XOR    = 4'h7,
        OP_ADC    = 4'h8,
        OP_SBB    = 4'h9,
        OP_SHR    = 4'hA,
        OP_SHL    = 4'hB,
        OP_SPARE0 = 4'hC,
        OP_SPARE1 = 4'hD,
        OP_SPARE2 = 4'hE,
        OP_SPARE3 = 4'hF
    } alu_op_e;

    // Operation classes used by the result and flag selection.
    typedef enum logic [1:0] {
        CLS_PASS  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_LOGIC = 2'd2,
        CLS_SHIFT = 2'd3
    } alu_cls_e;

    // Map an operation code onto its class.
    function automatic alu_cls_e op_class(input alu_op_e op);
        alu_cls_e c;
        case (op)
            OP_INC, OP_DEC, OP_ADD, OP_ADC, OP_SBB: c = CLS_ARITH;
            OP_NOT, OP_OR, OP_XOR:                  c = CLS_LOGIC;
            OP_SHR, OP_SHL:                         c = CLS_SHIFT;
            default:                                c = CLS_PASS;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_alu_opsel.sv
// Module acc_alu_opsel
// Builds the second adder operand and adder carry for every arithmetic
// code so that a single adder serves increment, decrement, add, add with
// carry and subtract with borrow. Subtraction is done as A + ~B + ~borrow,
// so the adder's carry out must be inverted to read as a borrow; the
// flag 'borrow_mode' tells the top to do that.
// Assumes: purely combinational, no state.
module acc_alu_opsel
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   op_b,
    input  logic           carry_in,
    output logic [W-1:0]   add_y,
    output logic           add_cin,
    output logic           borrow_mode
);

    // Select adder operand, adder carry and borrow sense from the code.
    always_comb begin
        add_y       = '0;
        add_cin     = 1'b0;
        borrow_mode = 1'b0;
        case (op)
            OP_INC: begin
                add_y   = '0;
                add_cin = 1'b1;
            end
            OP_DEC: begin
                add_y       = '1;
                add_cin     = 1'b0;
                borrow_mode = 1'b1;
            end
            OP_ADD: begin
                add_y   = op_b;
                add_cin = 1'b0;
            end
            OP_ADC: begin
                add_y   = op_b;
                add_cin = carry_in;
            end
            OP_SBB: begin
                add_y       = ~op_b;
                add_cin     = ~carry_in;
                borrow_mode = 1'b1;
            end
            default: begin
                add_y       = '0;
                add_cin     = 1'b0;
                borrow_mode = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_adder.sv
// Module acc_alu_adder
// Ripple-carry adder built from one full-adder cell per bit. It reports
// the carry out of the top bit and signed overflow, taken as the XOR of
// the carries into and out of the top bit.
// Assumes W >= 2.
module acc_alu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    localparam int MSB = W - 1;

    logic [W:0] chain;

    assign chain[0] = cin;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_cell
        logic prop;
        assign prop         = a[i] ^ y[i];
        assign sum[i]       = prop ^ chain[i];
        assign chain[i + 1] = (a[i] & y[i]) | (chain[i] & prop);
    end

    assign cout = chain[W];
    assign ovf  = chain[W] ^ chain[MSB];

    // Cross-check the carry-chain overflow against the sign rule and the
    // carry chain against wide arithmetic.
    always_comb begin
        AST_ADDER_OVF: assert (ovf == ((a[MSB] == y[MSB]) && (sum[MSB] != a[MSB])))
            else $error("adder overflow disagrees with sign rule"); // R6
        AST_ADDER_SUM: assert ({cout, sum} == ({1'b0, a} + {1'b0, y} + {{W{1'b0}}, cin}))
            else $error("adder sum disagrees with wide add"); // R4
    end

endmodule

// File: rtl/acc_alu_bitwise.sv
// Module acc_alu_bitwise
// Logic functions of the ALU: invert A, A OR B, A XOR B. Any other code
// gives zero; the top only uses this output for the logic codes.
// Assumes: purely combinational.
module acc_alu_bitwise
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);

    // Pick the bitwise function named by the code.
    always_comb begin
        case (op)
            OP_NOT:  res = ~a;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu_shifter.sv
// Module acc_alu_shifter
// One-place logical shift of A in either direction with zero fill; also
// returns the bit that leaves the word.
// Assumes W >= 2; 'to_left' selects the direction.
module acc_alu_shifter #(
    parameter int W = 16
) (
    input  logic         to_left,
    input  logic [W-1:0] a,
    output logic [W-1:0] res,
    output logic         out_bit
);

    localparam int MSB = W - 1;

    // Move A one place and capture the bit pushed out.
    always_comb begin
        if (to_left) begin
            res     = {a[MSB-1:0], 1'b0};
            out_bit = a[MSB];
        end else begin
            res     = {1'b0, a[MSB:1]};
            out_bit = a[0];
        end
    end

endmodule

// File: rtl/acc_alu.sv
// Module acc_alu
// Combinational ALU for an accumulator processor. Combines the operand
// selector, the shared adder, the bitwise unit and the shifter, then
// selects the result and builds carry, sign, zero and overflow.
// Assumes the caller registers result and flags; no state is held here.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic [3:0]   mode,
    output logic [W-1:0] result,
    output logic         flag_carry,
    output logic         flag_sign,
    output logic         flag_zero,
    output logic         flag_ovf
);

    localparam int MSB = W - 1;

    alu_op_e  op;
    alu_cls_e cls;

    logic [W-1:0] add_y;
    logic         add_cin;
    logic         borrow_mode;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;
    logic         shift_out;

    assign op  = alu_op_e'(mode);
    assign cls = op_class(op);

    acc_alu_opsel #(.W(W)) u_opsel (
        .op          (op),
        .op_b        (op_b),
        .carry_in    (carry_in),
        .add_y       (add_y),
        .add_cin     (add_cin),
        .borrow_mode (borrow_mode)
    );

    acc_alu_adder #(.W(W)) u_adder (
        .a    (op_a),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    acc_alu_bitwise #(.W(W)) u_bitwise (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .res (logic_res)
    );

    acc_alu_shifter #(.W(W)) u_shifter (
        .to_left (op == OP_SHL),
        .a       (op_a),
        .res     (shift_res),
        .out_bit (shift_out)
    );

    // Select the result word and the class-dependent carry and overflow.
    always_comb begin
        case (cls)
            CLS_ARITH: begin
                result     = add_sum;
                flag_carry = borrow_mode ? ~add_cout : add_cout;
                flag_ovf   = add_ovf;
            end
            CLS_LOGIC: begin
                result     = logic_res;
                flag_carry = 1'b0;
                flag_ovf   = 1'b0;
            end
            CLS_SHIFT: begin
                result     = shift_res;
                flag_carry = shift_out;
                flag_ovf   = 1'b0;
            end
            default: begin
                result     = (op == OP_PASS_B) ? op_b : op_a;
                flag_carry = 1'b0;
                flag_ovf   = 1'b0;
            end
        endcase
    end

    // Derive the sign and zero flags from the chosen result.
    always_comb begin
        flag_sign = result[MSB];
        flag_zero = ~|result;
    end

    // Port-level checks of each operation family against wide arithmetic.
    always_comb begin
        if (op == OP_PASS_A || op == OP_SPARE0 || op == OP_SPARE1 ||
            op == OP_SPARE2 || op == OP_SPARE3) begin
            AST_PASS_A: assert (result == op_a && !flag_carry && !flag_ovf)
                else $error("pass code did not copy A"); // R1
        end
        if (op == OP_INC) begin
            AST_INC_WRAP: assert ({flag_carry, result} == ({1'b0, op_a} + {{W{1'b0}}, 1'b1}))
                else $error("increment mismatch"); // R2
        end
        if (cls == CLS_LOGIC) begin
            AST_LOGIC_FLAGS: assert (!flag_carry && !flag_ovf)
                else $error("logic code raised carry or overflow"); // R3
        end
        if (op == OP_ADD) begin
            AST_ADD_SUM: assert ({flag_carry, result} == ({1'b0, op_a} + {1'b0, op_b}))
                else $error("add mismatch"); // R4
        end
        if (op == OP_SBB) begin
            AST_SBB_BORROW: assert (flag_carry ==
                    ({1'b0, op_a} < ({1'b0, op_b} + {{W{1'b0}}, carry_in})))
                else $error("subtract borrow mismatch"); // R5
        end
        if (op == OP_SHR) begin
            AST_SHR_FILL: assert (flag_carry == op_a[0] && !result[MSB])
                else $error("right shift mismatch"); // R7
        end
        if (cls != CLS_ARITH) begin
            AST_NO_OVERFLOW: assert (!flag_ovf)
                else $error("overflow outside arithmetic"); // R6
        end
    end

endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;

    localparam int W      = 16;
    localparam int NVEC   = 31;
    localparam int LIMIT  = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [3:0]   mode = 4'h0;
    logic [W-1:0] result;
    logic         flag_carry, flag_sign, flag_zero, flag_ovf;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu #(.W(W)) uut (
        .op_a       (op_a),
        .op_b       (op_b),
        .carry_in   (carry_in),
        .mode       (mode),
        .result     (result),
        .flag_carry (flag_carry),
        .flag_sign  (flag_sign),
        .flag_zero  (flag_zero),
        .flag_ovf   (flag_ovf)
    );

    // Vector: {req, mode, cin, a, b, result, flags{c,s,z,v}}
    localparam logic [60:0] VEC [NVEC] = '{
        {4'd1, 4'h0, 1'b0, 16'h1234, 16'h5678, 16'h1234, 4'b0000}, // R1
        {4'd1, 4'h1, 1'b1, 16'h1234, 16'h8765, 16'h8765, 4'b0100}, // R1
        {4'd1, 4'hC, 1'b1, 16'hABCD, 16'h0000, 16'hABCD, 4'b0100}, // R1
        {4'd1, 4'hF, 1'b0, 16'h0000, 16'hFFFF, 16'h0000, 4'b0010}, // R1
        {4'd2, 4'h2, 1'b0, 16'h0041, 16'h0000, 16'h0042, 4'b0000}, // R2
        {4'd2, 4'h2, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 4'b1010}, // R2 carry+zero
        {4'd6, 4'h2, 1'b0, 16'h7FFF, 16'h0000, 16'h8000, 4'b0101}, // R6
        {4'd2, 4'h3, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 4'b1100}, // R2
        {4'd6, 4'h3, 1'b0, 16'h8000, 16'h0000, 16'h7FFF, 4'b0001}, // R6
        {4'd3, 4'h4, 1'b0, 16'h00FF, 16'h1111, 16'hFF00, 4'b0100}, // R3
        {4'd3, 4'h6, 1'b0, 16'hF0F0, 16'h0F0F, 16'hFFFF, 4'b0100}, // R3
        {4'd3, 4'h7, 1'b0, 16'hAAAA, 16'hAAAA, 16'h0000, 4'b0010}, // R3
        {4'd4, 4'h5, 1'b1, 16'h1111, 16'h2222, 16'h3333, 4'b0000}, // R4
        {4'd4, 4'h5, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 4'b1010}, // R4
        {4'd4, 4'h8, 1'b1, 16'h1111, 16'h2222, 16'h3334, 4'b0000}, // R4
        {4'd6, 4'h8, 1'b1, 16'h7FFF, 16'h0000, 16'h8000, 4'b0101}, // R6
        {4'd6, 4'h5, 1'b0, 16'h8000, 16'h8000, 16'h0000, 4'b1011}, // R6 ovf+zero
        {4'd5, 4'h9, 1'b0, 16'h5000, 16'h1000, 16'h4000, 4'b0000}, // R5
        {4'd5, 4'h9, 1'b1, 16'h5000, 16'h1000, 16'h3FFF, 4'b0000}, // R5
        {4'd5, 4'h9, 1'b0, 16'h0001, 16'h0002, 16'hFFFF, 4'b1100}, // R5
        {4'd5, 4'h9, 1'b1, 16'h0001, 16'h0001, 16'hFFFF, 4'b1100}, // R5
        {4'd6, 4'h9, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 4'b0001}, // R6
        {4'd5, 4'h9, 1'b1, 16'h0000, 16'hFFFF, 16'h0000, 4'b1010}, // R5
        {4'd6, 4'h9, 1'b0, 16'h7FFF, 16'hFFFF, 16'h8000, 4'b1101}, // R6
        {4'd7, 4'hA, 1'b0, 16'h8001, 16'h0000, 16'h4000, 4'b1000}, // R7
        {4'd7, 4'hA, 1'b0, 16'h0001, 16'h0000, 16'h0000, 4'b1010}, // R7
        {4'd7, 4'hB, 1'b0, 16'h8001, 16'h0000, 16'h0002, 4'b1000}, // R7
        {4'd7, 4'hB, 1'b0, 16'h4000, 16'h0000, 16'h8000, 4'b0100}, // R7
        {4'd9, 4'h7, 1'b1, 16'h1234, 16'h0000, 16'h1234, 4'b0000}, // R9
        {4'd9, 4'h2, 1'b1, 16'h0005, 16'h0000, 16'h0006, 4'b0000}, // R9
        {4'd9, 4'hA, 1'b1, 16'h0002, 16'h0000, 16'h0001, 4'b0000}  // R9
    };

    task automatic check_out(input string tag, input logic [W-1:0] exp_res,
                             input logic [3:0] exp_flags);
        logic [3:0] got;
        got = {flag_carry, flag_sign, flag_zero, flag_ovf};
        checks++;
        if (result !== exp_res || got !== exp_flags) begin
            errors++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     tag, result, got, exp_res, exp_flags);
        end
    endtask

    task automatic apply(input logic [3:0] m, input logic c,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        mode = m; carry_in = c; op_a = a; op_b = b;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset phase: zero inputs, code 0000 (R1, R8).
        repeat (3) @(posedge clk);
        #1;
        check_out("R1 reset-time zero inputs", 16'h0000, 4'b0010);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table.
        for (int i = 0; i < NVEC; i++) begin
            logic [60:0] v;
            string tag;
            v = VEC[i];
            apply(v[56:53], v[52], v[51:36], v[35:20]);
            tag = $sformatf("R%0d vector %0d", v[60:57], i);
            check_out(tag, v[19:4], v[3:0]);
        end

        // R8: sign and zero over walking-one and zero values through code 0001.
        apply(4'h1, 1'b0, 16'hFFFF, 16'h0000);
        check_out("R8 zero word", 16'h0000, 4'b0010);
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] val;
            val = 16'h1 << k;
            apply(4'h1, 1'b0, 16'h0000, val);
            check_out($sformatf("R8 walking one %0d", k), val,
                      {1'b0, val[W-1], 1'b0, 1'b0});
        end

        // R9: carry_in changes nothing outside codes 1000 and 1001.
        for (int m = 0; m < 16; m++) begin
            logic [W-1:0] r0;
            logic [3:0]   f0;
            if (m == 8 || m == 9) continue;
            apply(4'(m), 1'b0, 16'h8421, 16'h1248);
            r0 = result;
            f0 = {flag_carry, flag_sign, flag_zero, flag_ovf};
            apply(4'(m), 1'b1, 16'h8421, 16'h1248);
            check_out($sformatf("R9 code %0d carry_in=1", m), r0, f0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule